// File: doc/BRIEF.md
# Software (Xon/Xoff) Flow Controller

This block performs in-band flow control for a single serial channel. On the receive side it inspects every character the deserializer hands over and compares it with four host-programmable 8-bit characters, two that resume the local transmitter and two that pause it. A match either halts the local transmitter or releases it, and a pause match also pulses an interrupt request of its own. Matched control characters are kept out of the receive FIFO.

On the transmit side the block watches the receive FIFO fill level. When the level reaches a trigger threshold it queues a pause character for the remote end. When the level later drops below a lower resume threshold it queues a resume character. The block also arbitrates the start of each transmitted character. A queued control character wins over the next FIFO data character, and a character already in the shifter is never cut short.

Matching and insertion each have a mode field. Matching can use either of two single characters or a fixed two-character sequence. Insertion can send the first character of a kind, the second, or both in order. The shifters and FIFOs sit outside the block and are represented by a received-character strobe, a fill level and a start/idle handshake.

Top module: `sfc_top`

## Requirements
- R1: After reset all four character registers read 0x00, `tx_halted` and `xoff_irq` are low, and no control character is queued.
- R2: A write with `reg_we` high stores `reg_wdata` into the register chosen by `reg_addr` on the next clock edge. Address 0 holds resume char 1, 1 holds resume char 2, 2 holds pause char 1 and 3 holds pause char 2. `reg_rdata` shows the addressed register combinationally.
- R3: With `rx_mode` = 01 (single), a received character equal to either pause char halts the transmitter, and `tx_halted` is high from the next cycle. A character equal to either resume char (and to no pause char) clears `tx_halted` from the next cycle.
- R4: With `rx_mode` = 10 (pair), pause char 1 immediately followed by pause char 2 halts the transmitter, and resume char 1 followed by resume char 2 resumes it. A first character on its own has no effect. Any other character between the two resets the detector.
- R5: A received character that completes a match has `rx_push` low in its strobe cycle. Every other strobed character, including the first half of a pair, has `rx_push` high. `rx_push` is never high without `rx_valid`.
- R6: `xoff_irq` is a one-cycle pulse in the cycle after each pause match, and it is low otherwise.
- R7: A FIFO character starts (`tx_pop` high) only while `tx_halted` is low, and every start (`tx_start`) needs `tx_idle`. A pause match in the same cycle as a FIFO start does not cancel that start.
- R8: With `tx_mode` not 00, a fill level at or above `trig_lvl` queues the pause kind once, and a later level below `resume_lvl` queues the resume kind once. A level one below the trigger queues nothing.
- R9: The `tx_mode` setting decides which characters are sent. 01 sends char 1 of the kind, 10 sends char 2, and 11 sends char 1 then char 2.
- R10: While a control character is queued, `tx_idle` starts it with `tx_pop` low and `tx_char` equal to it, even while `tx_halted` is high.
- R11: With `rx_mode` 00 or 11, no character is matched, every strobed character is pushed, and `tx_halted` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Character register write strobe |
| reg_addr | input | 2 | Character register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| rx_mode | input | 2 | Receive compare mode: 00 off, 01 single, 10 pair, 11 off |
| tx_mode | input | 2 | Insertion mode: 00 off, 01 char 1, 10 char 2, 11 both |
| trig_lvl | input | 7 | Fill level that asks the remote end to pause |
| resume_lvl | input | 7 | Fill level below which the remote end may resume |
| rx_level | input | 7 | Current receive FIFO fill level |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_push | output | 1 | Write the strobed character into the receive FIFO |
| tx_idle | input | 1 | Transmit shifter can take a character this cycle |
| tx_avail | input | 1 | Transmit FIFO holds data |
| tx_fifo_char | input | 8 | Head of the transmit FIFO |
| tx_start | output | 1 | Load `tx_char` into the shifter this cycle |
| tx_pop | output | 1 | The loaded character comes from the transmit FIFO |
| tx_char | output | 8 | Character to load |
| tx_halted | output | 1 | Local transmitter paused by the remote end |
| xoff_irq | output | 1 | Pause-match interrupt pulse |

## Verification
The receive matcher and the transmit arbiter can act in the same cycle. A pause character can arrive while the shifter is idle and a FIFO character is waiting, and a queued control character can compete with FIFO data while the transmitter is halted. The bench strobes the pause character in the very cycle the FIFO start is offered. It expects that start to stand and FIFO starts to stop from the next cycle. It also raises the fill level while halted and expects the control characters to go out ahead of the data, with the data still held back afterwards.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    RXM_OFF    = 2'b00,
    RXM_SINGLE = 2'b01,
    RXM_PAIR   = 2'b10,
    RXM_RSVD   = 2'b11
  } rx_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_ON1  = 2'b01,
    SEQ_OFF1 = 2'b10
  } seq_e;

  // number of control characters queued for one request
  function automatic logic [1:0] ins_len(input logic [1:0] txm);
    case (txm)
      2'b00:   return 2'd0;
      2'b11:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // which character of a kind (0 = first, 1 = second) goes out next
  function automatic logic ins_pos(input logic [1:0] txm, input logic [1:0] left);
    if (txm == 2'b10) return 1'b1;
    if (txm == 2'b11 && left == 2'd1) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/sfc_char_regs.sv
module sfc_char_regs #(
  parameter int CW   = 8,
  parameter int NREG = 4,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [CW-1:0]            wdata,
  output logic [CW-1:0]            rdata,
  output logic [NREG-1:0][CW-1:0]  chars
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   chars[g] <= '0;
      else if (we && addr == AW'(g))                chars[g] <= wdata;
    end
  end

  assign rdata = chars[addr];

endmodule

// File: rtl/sfc_rx_match.sv
module sfc_rx_match
  import sfc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rx_mode,
  input  logic               rx_valid,
  input  logic [CW-1:0]      rx_char,
  input  logic [CW-1:0]      on1,
  input  logic [CW-1:0]      on2,
  input  logic [CW-1:0]      off1,
  input  logic [CW-1:0]      off2,
  output logic               hit_on,
  output logic               hit_off,
  output logic               halted,
  output logic               xoff_irq
);

  function automatic logic either_eq(input logic [CW-1:0] c, a, b);
    return (c == a) || (c == b);
  endfunction

  rx_mode_e mode;
  seq_e     seq_q, seq_nx;
  logic     active;

  assign mode   = rx_mode_e'(rx_mode);
  assign active = (mode == RXM_SINGLE) || (mode == RXM_PAIR);

  always_comb begin
    hit_on  = 1'b0;
    hit_off = 1'b0;
    seq_nx  = SEQ_IDLE;
    if (mode == RXM_SINGLE) begin
      hit_off = either_eq(rx_char, off1, off2);
      hit_on  = !hit_off && either_eq(rx_char, on1, on2);
    end else if (mode == RXM_PAIR) begin
      if (seq_q == SEQ_OFF1 && rx_char == off2)     hit_off = 1'b1;
      else if (seq_q == SEQ_ON1 && rx_char == on2)  hit_on  = 1'b1;
      if (hit_on || hit_off)                        seq_nx = SEQ_IDLE;
      else if (rx_char == off1)                     seq_nx = SEQ_OFF1;
      else if (rx_char == on1)                      seq_nx = SEQ_ON1;
      else                                          seq_nx = SEQ_IDLE;
    end
    if (!rx_valid) begin
      hit_on  = 1'b0;
      hit_off = 1'b0;
      seq_nx  = (mode == RXM_PAIR) ? seq_q : SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q    <= SEQ_IDLE;
      halted   <= 1'b0;
      xoff_irq <= 1'b0;
    end else begin
      seq_q    <= seq_nx;
      xoff_irq <= hit_off;
      if (!active)      halted <= 1'b0;
      else if (hit_off) halted <= 1'b1;
      else if (hit_on)  halted <= 1'b0;
    end
  end

endmodule

// File: rtl/sfc_tx_insert.sv
module sfc_tx_insert
  import sfc_pkg::*;
#(
  parameter int CW   = 8,
  parameter int LW   = 7,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              tx_mode,
  input  logic [LW-1:0]           rx_level,
  input  logic [LW-1:0]           trig_lvl,
  input  logic [LW-1:0]           resume_lvl,
  input  logic [NREG-1:0][CW-1:0] chars,
  input  logic                    halted,
  input  logic                    tx_idle,
  input  logic                    tx_avail,
  input  logic [CW-1:0]           tx_fifo_char,
  output logic                    tx_start,
  output logic                    tx_pop,
  output logic [CW-1:0]           tx_char,
  output logic                    ins_busy,
  output logic                    ins_grant
);

  function automatic logic need_pause(input logic [LW-1:0] lvl, trig);
    return lvl >= trig;
  endfunction

  function automatic logic may_resume(input logic [LW-1:0] lvl, res);
    return lvl < res;
  endfunction

  logic       rem_paused_q;
  logic       kind_off_q;
  logic [1:0] left_q;
  logic [1:0] mode_q;
  logic       fifo_grant;
  logic [1:0] idx;

  assign ins_busy   = (left_q != 2'd0);
  assign ins_grant  = tx_idle && ins_busy;
  assign fifo_grant = tx_idle && !ins_busy && tx_avail && !halted;
  assign tx_start   = ins_grant || fifo_grant;
  assign tx_pop     = fifo_grant;
  assign idx        = {kind_off_q, ins_pos(mode_q, left_q)};
  assign tx_char    = ins_busy ? chars[idx] : tx_fifo_char;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_paused_q <= 1'b0;
      kind_off_q   <= 1'b0;
      left_q       <= 2'd0;
      mode_q       <= 2'b00;
    end else if (ins_busy) begin
      if (ins_grant) left_q <= left_q - 2'd1;
    end else if (tx_mode != 2'b00) begin
      if (!rem_paused_q && need_pause(rx_level, trig_lvl)) begin
        rem_paused_q <= 1'b1;
        kind_off_q   <= 1'b1;
        left_q       <= ins_len(tx_mode);
        mode_q       <= tx_mode;
      end else if (rem_paused_q && may_resume(rx_level, resume_lvl)) begin
        rem_paused_q <= 1'b0;
        kind_off_q   <= 1'b0;
        left_q       <= ins_len(tx_mode);
        mode_q       <= tx_mode;
      end
    end
  end

endmodule

// File: rtl/sfc_top.sv
module sfc_top #(
  parameter int CW = 8,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic [1:0]    rx_mode,
  input  logic [1:0]    tx_mode,
  input  logic [LW-1:0] trig_lvl,
  input  logic [LW-1:0] resume_lvl,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_char,
  output logic          rx_push,
  input  logic          tx_idle,
  input  logic          tx_avail,
  input  logic [CW-1:0] tx_fifo_char,
  output logic          tx_start,
  output logic          tx_pop,
  output logic [CW-1:0] tx_char,
  output logic          tx_halted,
  output logic          xoff_irq
);

  localparam int NREG = 4;
  localparam int AW   = $clog2(NREG);

  logic [NREG-1:0][CW-1:0] chars;
  logic hit_on_w, hit_off_w, ins_busy_w, ins_grant_w;

  sfc_char_regs #(.CW(CW), .NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .chars(chars)
  );

  sfc_rx_match #(.CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .rx_valid(rx_valid),
    .rx_char(rx_char), .on1(chars[0]), .on2(chars[1]), .off1(chars[2]),
    .off2(chars[3]), .hit_on(hit_on_w), .hit_off(hit_off_w),
    .halted(tx_halted), .xoff_irq(xoff_irq)
  );

  assign rx_push = rx_valid && !(hit_on_w || hit_off_w);

  sfc_tx_insert #(.CW(CW), .LW(LW), .NREG(NREG)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_level(rx_level),
    .trig_lvl(trig_lvl), .resume_lvl(resume_lvl), .chars(chars),
    .halted(tx_halted), .tx_idle(tx_idle), .tx_avail(tx_avail),
    .tx_fifo_char(tx_fifo_char), .tx_start(tx_start), .tx_pop(tx_pop),
    .tx_char(tx_char), .ins_busy(ins_busy_w), .ins_grant(ins_grant_w)
  );

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rx_mode,
  input logic       rx_valid,
  input logic       rx_push,
  input logic       hit_on,
  input logic       hit_off,
  input logic       tx_halted,
  input logic       xoff_irq,
  input logic       tx_idle,
  input logic       tx_start,
  input logic       tx_pop,
  input logic       ins_busy
);

  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_idle); // R7
  AST_POP_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_halted); // R7
  AST_INSERT_BEATS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_busy && tx_idle) |-> (tx_start && !tx_pop)); // R10
  AST_MATCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_on || hit_off) |-> !rx_push); // R5
  AST_PUSH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_valid); // R5
  AST_PAUSE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_off |=> tx_halted); // R3
  AST_RESUME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_on |=> !tx_halted); // R3
  AST_IRQ_ON_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_off |=> xoff_irq); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_off |=> !xoff_irq); // R6
  AST_OFF_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == 2'b00 || rx_mode == 2'b11) |=> !tx_halted); // R11

endmodule

bind sfc_top sfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .rx_valid(rx_valid),
  .rx_push(rx_push), .hit_on(hit_on_w), .hit_off(hit_off_w),
  .tx_halted(tx_halted), .xoff_irq(xoff_irq), .tx_idle(tx_idle),
  .tx_start(tx_start), .tx_pop(tx_pop), .ins_busy(ins_busy_w)
);

// File: tb/sfc_top_bench.sv
module sfc_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] rx_mode = 2'b00, tx_mode = 2'b00;
  logic [6:0] trig_lvl = 7'd48, resume_lvl = 7'd16, rx_level = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = '0;
  logic       rx_push;
  logic       tx_idle = 1'b0, tx_avail = 1'b0;
  logic [7:0] tx_fifo_char = 8'hA5;
  logic       tx_start, tx_pop, tx_halted, xoff_irq;
  logic [7:0] tx_char;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h12, OFF1 = 8'h13, OFF2 = 8'h14;

  always #10 clk = ~clk;

  sfc_top u_sfc_top (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] c, output logic pushed);
    rx_valid = 1'b1; rx_char = c;
    #1 pushed = rx_push;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 halted", 32'(tx_halted), 0);
    check("R1 irq", 32'(xoff_irq), 0);
    for (int i = 0; i < 4; i++) begin
      reg_addr = 2'(i); #1;
      check("R1 reg", 32'(reg_rdata), 0);
    end
    tx_idle = 1'b1; #1;
    check("R1 no queued char", 32'(tx_start), 0);
    tx_idle = 1'b0;
  endtask

  task automatic t_regs();
    wr(2'd0, ON1); wr(2'd1, ON2); wr(2'd2, OFF1); wr(2'd3, OFF2);
    reg_addr = 2'd0; #1 check("R2 addr0", 32'(reg_rdata), 32'(ON1));
    reg_addr = 2'd1; #1 check("R2 addr1", 32'(reg_rdata), 32'(ON2));
    reg_addr = 2'd2; #1 check("R2 addr2", 32'(reg_rdata), 32'(OFF1));
    reg_addr = 2'd3; #1 check("R2 addr3", 32'(reg_rdata), 32'(OFF2));
  endtask

  task automatic t_single();
    logic p;
    rx_mode = 2'b01;
    send(OFF2, p);
    check("R5 pause not pushed", 32'(p), 0);
    check("R3 halted after pause2", 32'(tx_halted), 1);
    check("R6 irq pulse", 32'(xoff_irq), 1);
    tx_idle = 1'b1; tx_avail = 1'b1; #1;
    check("R7 no fifo start halted", 32'(tx_start), 0);
    tx_idle = 1'b0;
    tick();
    check("R6 irq one cycle", 32'(xoff_irq), 0);
    send(ON2, p);
    check("R5 resume not pushed", 32'(p), 0);
    check("R3 released", 32'(tx_halted), 0);
    check("R6 no irq on resume", 32'(xoff_irq), 0);
    send(8'h41, p);
    check("R5 data pushed", 32'(p), 1);
  endtask

  task automatic t_pair();
    logic p;
    rx_mode = 2'b10;
    send(OFF1, p);
    check("R5 first half pushed", 32'(p), 1);
    check("R4 first alone no halt", 32'(tx_halted), 0);
    send(OFF2, p);
    check("R5 pair end dropped", 32'(p), 0);
    check("R4 pair halts", 32'(tx_halted), 1);
    send(ON1, p); send(8'h55, p); send(ON2, p);
    check("R4 broken pair ignored", 32'(tx_halted), 1);
    check("R4 broken pair pushed", 32'(p), 1);
    send(ON1, p); send(ON2, p);
    check("R4 pair resumes", 32'(tx_halted), 0);
  endtask

  task automatic t_disabled();
    logic p;
    rx_mode = 2'b01;
    send(OFF1, p);
    check("R3 halted before off", 32'(tx_halted), 1);
    rx_mode = 2'b00;
    tick();
    check("R11 off clears halt", 32'(tx_halted), 0);
    send(OFF1, p);
    check("R11 char pushed", 32'(p), 1);
    check("R11 no halt", 32'(tx_halted), 0);
    rx_mode = 2'b11;
    send(OFF1, p);
    check("R11 mode3 pushed", 32'(p), 1);
  endtask

  task automatic t_coincide();
    logic p;
    rx_mode = 2'b01; tx_avail = 1'b1; tx_idle = 1'b1;
    rx_valid = 1'b1; rx_char = OFF1; #1;
    check("R7 start stands on pause", 32'(tx_pop), 1);
    tick();
    rx_valid = 1'b0; #1;
    check("R7 fifo stops next cycle", 32'(tx_pop), 0);
    tx_idle = 1'b0;
    check("R3 halted coincide", 32'(tx_halted), 1);
    p = 1'b0;
  endtask

  task automatic t_insert();
    logic p;
    tx_mode = 2'b11; tx_avail = 1'b1;
    rx_level = 7'd47; tick(); tick();
    tx_idle = 1'b1; #1;
    check("R8 below trigger nothing", 32'(tx_start), 0);
    tx_idle = 1'b0;
    rx_level = 7'd48; tick();
    tx_idle = 1'b1; #1;
    check("R10 insert while halted", 32'(tx_start), 1);
    check("R10 not from fifo", 32'(tx_pop), 0);
    check("R8 pause char1", 32'(tx_char), 32'(OFF1));
    tick(); #1;
    check("R9 pause char2", 32'(tx_char), 32'(OFF2));
    check("R9 second start", 32'(tx_start), 1);
    tick(); #1;
    check("R7 halted after insert", 32'(tx_start), 0);
    tx_idle = 1'b0;
    send(ON1, p);
    tx_idle = 1'b1; #1;
    check("R7 fifo after resume", 32'(tx_pop), 1);
    check("R7 fifo char", 32'(tx_char), 32'hA5);
    tx_idle = 1'b0;
    rx_level = 7'd20; tick(); tick();
    tx_idle = 1'b1; #1;
    check("R8 above resume no insert", 32'(tx_pop), 1);
    tx_idle = 1'b0;
    rx_level = 7'd15; tick();
    tx_idle = 1'b1; #1;
    check("R8 resume char1", 32'(tx_char), 32'(ON1));
    check("R10 resume before data", 32'(tx_pop), 0);
    tick(); #1;
    check("R9 resume char2", 32'(tx_char), 32'(ON2));
    tick(); #1;
    check("R10 data after insert", 32'(tx_pop), 1);
    tx_idle = 1'b0;
  endtask

  task automatic t_txmode();
    tx_mode = 2'b10; rx_level = 7'd60; tick();
    tx_idle = 1'b1; #1;
    check("R9 mode10 pause char2", 32'(tx_char), 32'(OFF2));
    tick(); #1;
    check("R9 mode10 single char", 32'(tx_pop), 1);
    tx_idle = 1'b0;
    tx_mode = 2'b01; rx_level = 7'd0; tick();
    tx_idle = 1'b1; #1;
    check("R9 mode01 resume char1", 32'(tx_char), 32'(ON1));
    tick(); #1;
    check("R9 mode01 single char", 32'(tx_pop), 1);
    tx_idle = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_single();
    t_pair();
    t_disabled();
    t_coincide();
    t_insert();
    t_txmode();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule